// File: doc/BRIEF.md
# Johnson Decade Counter with Decoder

This block divides a count stream by ten. A five-bit twisted-ring register walks through ten legal codes. Each code drives exactly one of ten decoded outputs, so the outputs behave as a one-hot decimal position indicator. A carry output is high for the first half of each decade and low for the second half, which gives a square wave at one tenth of the advance rate.

Everything runs on one system clock. The count-clock input, the active-low enable input and the reset input may all be asynchronous, so each one passes through a two-flop synchronizer. Two kinds of edge advance the count. The first is a rising count-clock edge while the enable is low. The second is a falling enable edge while the count clock is high, which lets the enable pin act as a negative-edge clock. If both kinds arrive in the same system-clock cycle, the count advances only once. A synchronized high reset returns the ring to state zero.

The ring state is an enumerated type with ten named codes. S0 is 00000. S1 to S4 fill the register with ones from bit 0 upwards, giving 00001, 00011, 00111 and 01111. S5 is 11111. S6 to S9 clear bits from bit 0 upwards, giving 11110, 11100, 11000 and 10000. The only transition is ADVANCE, which moves Sk to S(k+1) and S9 to S0. Any unused code goes to S0 on the next ADVANCE. RESET goes to S0 from any state. The edge qualifier classifies each cycle as TRIG_NONE, TRIG_CLK, TRIG_EN or TRIG_BOTH, and any class except TRIG_NONE is an ADVANCE.

Top module: `jdc_decade_counter`

## Requirements
- R1: While reset is high, and within three system-clock edges of it going high, the decoded outputs equal 10'b0000000001 and carry is 1. This holds whatever the count-clock and enable inputs do.
- R2: Exactly one decoded output is high at all times, and its bit index equals the current count 0 to 9.
- R3: A rising edge on the count clock while the enable (active low, 0 = enabled) is 0 advances the count by one. Count 9 wraps to 0.
- R4: While the enable is 1, rising edges on the count clock leave the outputs unchanged.
- R5: A falling edge on the enable while the count clock is 1 advances the count by one. A falling enable edge while the count clock is 0 does not advance. A rising enable edge and a falling count-clock edge never advance.
- R6: A count-clock rise and a qualifying enable fall seen in the same system-clock cycle advance the count by exactly one.
- R7: Carry is 1 when the count is 0 to 4 and 0 when it is 5 to 9.
- R8: An input change that qualifies shows at the outputs on the third rising system-clock edge after it. The outputs still show the old count after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset, synchronized inside |
| cnt_clk | input | 1 | Asynchronous count clock |
| cnt_en_n | input | 1 | Asynchronous active-low enable; its falling edge also counts |
| dec_out | output | 10 | One-hot decoded count, bit k high for count k |
| carry | output | 1 | High for counts 0 to 4 |

## Verification
The ring is driven through more than a full decade of count-clock pulses, which exposes wrap errors and carry-phase errors. It is then pulsed with the enable held high, which separates a hold from a count. An enable-falling sequence, run once with the count clock high and once with it low, shows whether the enable acts as a second clock only while the count clock is high. Raising the count clock and lowering the enable in the same cycle distinguishes a single advance from a double one. A sample taken one edge early pins the three-edge latency. Pulses applied while reset is high confirm that reset dominates.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
    localparam int STAGES     = 5;
    localparam int NOUT       = 2 * STAGES;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [STAGES-1:0] {
        S0 = 5'b00000,
        S1 = 5'b00001,
        S2 = 5'b00011,
        S3 = 5'b00111,
        S4 = 5'b01111,
        S5 = 5'b11111,
        S6 = 5'b11110,
        S7 = 5'b11100,
        S8 = 5'b11000,
        S9 = 5'b10000
    } jstate_t;

    typedef enum logic [1:0] {
        TRIG_NONE,
        TRIG_CLK,
        TRIG_EN,
        TRIG_BOTH
    } trig_t;
endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/jdc_trigger.sv
module jdc_trigger
    import jdc_pkg::*;
(
    input  logic  clk,
    input  logic  clk_s,
    input  logic  en_n_s,
    output trig_t kind,
    output logic  advance
);
    logic clk_q;
    logic en_n_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        clk_q  <= clk_s;
        en_n_q <= en_n_s;
    end

    always_comb begin
        rise = clk_s & ~clk_q & ~en_n_s;
        fall = ~en_n_s & en_n_q & clk_s;
        unique case ({rise, fall})
            2'b10:   kind = TRIG_CLK;
            2'b01:   kind = TRIG_EN;
            2'b11:   kind = TRIG_BOTH;
            default: kind = TRIG_NONE;
        endcase
    end

    assign advance = (kind != TRIG_NONE);
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
    import jdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_s,
    input  logic    advance,
    output jstate_t state
);
    jstate_t nxt;

    always_ff @(posedge clk) begin
        if (rst_s) begin
            state <= S0;
        end else if (advance) begin
            state <= nxt;
        end
    end

    always_comb begin
        unique case (state)
            S0:      nxt = S1;
            S1:      nxt = S2;
            S2:      nxt = S3;
            S3:      nxt = S4;
            S4:      nxt = S5;
            S5:      nxt = S6;
            S6:      nxt = S7;
            S7:      nxt = S8;
            S8:      nxt = S9;
            S9:      nxt = S0;
            default: nxt = S0;
        endcase
    end
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
    parameter int STAGES = 5,
    localparam int NOUT  = 2 * STAGES
) (
    input  logic [STAGES-1:0] q,
    output logic [NOUT-1:0]   dec,
    output logic              carry
);
    assign dec[0]      = ~q[STAGES-1] & ~q[0];
    assign dec[STAGES] =  q[STAGES-1] &  q[0];

    for (genvar k = 1; k < STAGES; k++) begin : g_pair
        assign dec[k]          =  q[k-1] & ~q[k];
        assign dec[STAGES + k] = ~q[k-1] &  q[k];
    end

    assign carry = ~q[STAGES-1];
endmodule

// File: rtl/jdc_decade_counter.sv
module jdc_decade_counter
    import jdc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_clk,
    input  logic            cnt_en_n,
    output logic [NOUT-1:0] dec_out,
    output logic            carry
);
    logic [2:0] raw_in;
    logic [2:0] sync_out;
    logic       rst_s;
    logic       clk_s;
    logic       en_n_s;
    logic       advance;
    trig_t      kind;
    jstate_t    state;

    assign raw_in = {rst, cnt_clk, cnt_en_n};
    assign {rst_s, clk_s, en_n_s} = sync_out;

    jdc_sync #(.WIDTH(3), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .d   (raw_in),
        .q   (sync_out)
    );

    jdc_trigger u_trig (
        .clk     (clk),
        .clk_s   (clk_s),
        .en_n_s  (en_n_s),
        .kind    (kind),
        .advance (advance)
    );

    jdc_ring u_ring (
        .clk     (clk),
        .rst_s   (rst_s),
        .advance (advance),
        .state   (state)
    );

    jdc_decode #(.STAGES(STAGES)) u_dec (
        .q     (state),
        .dec   (dec_out),
        .carry (carry)
    );
endmodule

// File: rtl/jdc_decade_counter_chk.sv
module jdc_decade_counter_chk (
    input logic       clk,
    input logic       rst_s,
    input logic       advance,
    input logic [9:0] dec_out,
    input logic       carry
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst_s |=> (dec_out == 10'd1 && carry));

    // R2
    one_hot_chk: assert property (@(posedge clk) disable iff (rst_s)
        $countones(dec_out) == 1);

    // R7
    carry_phase_chk: assert property (@(posedge clk) disable iff (rst_s)
        carry == (dec_out[4:0] != 5'd0));

    // R3
    step_once_chk: assert property (@(posedge clk) disable iff (rst_s)
        advance |=> (dec_out == {$past(dec_out[8:0]), $past(dec_out[9])}));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst_s)
        !advance |=> $stable(dec_out));
endmodule

bind jdc_decade_counter jdc_decade_counter_chk u_chk (
    .clk     (clk),
    .rst_s   (rst_s),
    .advance (advance),
    .dec_out (dec_out),
    .carry   (carry)
);

// File: tb/jdc_decade_counter_tb.sv
`timescale 1ns/1ps
module jdc_decade_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_clk = 1'b0;
    logic       cnt_en_n = 1'b0;
    logic [9:0] dec_out;
    logic       carry;

    int checks = 0;
    int fails  = 0;
    int expc   = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    jdc_decade_counter u_dut (
        .clk      (clk),
        .rst      (rst),
        .cnt_clk  (cnt_clk),
        .cnt_en_n (cnt_en_n),
        .dec_out  (dec_out),
        .carry    (carry)
    );

    task automatic chk(input string tag);
        logic [9:0] ed;
        logic       ec;
        ed = 10'd1 << expc;
        ec = (expc < 5);
        checks++;
        if (dec_out !== ed || carry !== ec) begin
            fails++;
            $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
                     tag, dec_out, carry, ed, ec);
        end
    endtask

    task automatic drive(input logic c, input logic e);
        cnt_clk  = c;
        cnt_en_n = e;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        expc = 0;
        chk("R1 reset state");
        drive(1'b1, 1'b0);
        chk("R1 clock high under reset");
        drive(1'b0, 1'b0);
        chk("R1 clock low under reset");
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 after release");
    endtask

    task automatic t_count_clk();
        for (int i = 0; i < 12; i++) begin
            drive(1'b1, 1'b0);
            expc = (expc + 1) % 10;
            chk("R3 R2 R7 count clock rise");
            drive(1'b0, 1'b0);
            chk("R3 count clock fall holds");
        end
    endtask

    task automatic t_inhibit();
        cnt_en_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 enable rise holds");
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b1);
            chk("R4 inhibited rise");
            drive(1'b0, 1'b1);
            chk("R4 inhibited fall");
        end
        drive(1'b0, 1'b0);
        chk("R5 enable fall with clock low");
    endtask

    task automatic t_en_edge();
        drive(1'b1, 1'b0);
        expc = (expc + 1) % 10;
        chk("R3 rise before enable clocking");
        drive(1'b1, 1'b1);
        chk("R5 enable rise with clock high");
        drive(1'b1, 1'b0);
        expc = (expc + 1) % 10;
        chk("R5 enable fall with clock high");
        drive(1'b0, 1'b0);
        chk("R5 clock fall holds");
    endtask

    task automatic t_both();
        drive(1'b0, 1'b1);
        chk("R6 setup");
        drive(1'b1, 1'b0);
        expc = (expc + 1) % 10;
        chk("R6 simultaneous edges");
        drive(1'b0, 1'b0);
    endtask

    task automatic t_latency();
        cnt_clk = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 old value after two edges");
        @(negedge clk);
        expc = (expc + 1) % 10;
        chk("R8 new value after three edges");
        drive(1'b0, 1'b0);
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b0);
            expc = (expc + 1) % 10;
            drive(1'b0, 1'b0);
        end
        chk("R1 nonzero before reset");
        rst = 1'b1;
        repeat (4) @(negedge clk);
        expc = 0;
        chk("R1 mid-count reset");
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b0);
        chk("R1 enable fall under reset");
        rst = 1'b0;
        drive(1'b0, 1'b0);
        chk("R1 released");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_count_clk();
        t_inhibit();
        t_en_edge();
        t_both();
        t_latency();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule